// File: doc/BRIEF.md
# Two-Bit Hysteresis Branch Predictor Table

This block holds a direct-mapped array of two-bit prediction entries, one per index formed from the low address bits of a branch instruction. A fetch stage presents an instruction address on the lookup port and receives, in the same cycle, a taken or not-taken guess. When the branch resolves later in the pipeline, the execute stage sends the branch address and its real outcome on the update port. The selected entry then steps through a four-state hysteresis cycle.

Each entry's upper bit is the guess it gives (1 means predict taken). Its lower bit tracks the most recent outcome. The states are visited as 00, 01, 11, 10, so a settled guess reverses only after two wrong outcomes in a row. This is not a saturating counter: a taken outcome in the weak-taken state 10 goes back to 11, and a not-taken outcome there drops straight to 00. Targets and tags are not stored; every address whose index bits match shares an entry.

Top module: `hyst_branch_predictor`

## Requirements
- R1: After reset every entry is 00, so a lookup at any address predicts not taken (`lk_taken` = 0).
- R2: An entry in 00 stays in 00 on a not-taken update and moves to 01 on a taken update; both states predict not taken.
- R3: An entry in 01 returns to 00 on a not-taken update and moves to 11 (predict taken) on a taken update.
- R4: An entry in 11 stays in 11 on a taken update and moves to 10 on a not-taken update; both states predict taken.
- R5: An entry in 10 returns to 11 on a taken update and falls to 00 (predict not taken) on a not-taken update.
- R6: With the default parameters the entry index is address bits [7:2]. Addresses that differ only in bits [1:0] or in bits above 7 select the same entry, and index 63 (address 0xFC) and index 0 (address 0x00) are separate entries.
- R7: The lookup is combinational from the stored state. An update takes effect at the rising clock edge, so a lookup of the entry being updated returns the old guess in that cycle and the new guess after the edge.
- R8: While `up_valid` is low, no entry changes, whatever `up_addr` and `up_taken` hold.
- R9: An update changes only the entry its index selects; all other entries keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; updates are written on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears every entry to 00 |
| lk_addr | input | ADDR_W (32) | Fetch address to predict |
| lk_taken | output | 1 | Prediction for `lk_addr`: 1 taken, 0 not taken |
| up_valid | input | 1 | High for one cycle per resolved branch |
| up_addr | input | ADDR_W (32) | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch: 1 taken |

## Verification
The state-transition assertions assume that `up_addr` and `up_taken` are stable and known in any cycle where `up_valid` is high. The idle assertion assumes nothing about those two inputs when `up_valid` is low. The stimulus drives every input on the falling edge and holds it through the next rising edge. Rows with `up_valid` low deliberately carry a taken outcome for a live index, so the idle rule is tested against an input that would move the entry. The lookup address is free in every cycle and is sometimes set equal to the update index, to exercise the read-before-write case.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef logic [1:0] bht_state_t;

    localparam bht_state_t ST_NT_FIRM = 2'b00;
    localparam bht_state_t ST_NT_SOFT = 2'b01;
    localparam bht_state_t ST_T_FIRM  = 2'b11;
    localparam bht_state_t ST_T_SOFT  = 2'b10;

endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 6,
    parameter int ALIGN_BITS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] unused_addr_copy;

    assign unused_addr_copy = addr;
    assign idx              = addr[ALIGN_BITS +: IDX_W];

    initial begin
        assert (ALIGN_BITS + IDX_W <= ADDR_W)
            else $error("index field does not fit in address");
    end
endmodule

// File: rtl/bht_hyst_next.sv
module bht_hyst_next
    import bht_pkg::*;
(
    input  bht_state_t cur,
    input  logic       taken,
    output bht_state_t nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_NT_FIRM: nxt = taken ? ST_NT_SOFT : ST_NT_FIRM;
            ST_NT_SOFT: nxt = taken ? ST_T_FIRM  : ST_NT_FIRM;
            ST_T_FIRM:  nxt = taken ? ST_T_FIRM  : ST_T_SOFT;
            ST_T_SOFT:  nxt = taken ? ST_T_FIRM  : ST_NT_FIRM;
            default:    nxt = ST_NT_FIRM;
        endcase
    end
endmodule

// File: rtl/hyst_branch_predictor.sv
module hyst_branch_predictor
    import bht_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 64,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_taken,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              up_taken
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        bht_state_t [ENTRIES-1:0] ent;
    } tbl_t;

    tbl_t              tbl_d, tbl_q;
    logic [IDX_W-1:0]  lk_idx, up_idx;
    bht_state_t        up_cur, up_nxt;

    bht_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS)) u_lk_index (
        .addr (lk_addr),
        .idx  (lk_idx)
    );

    bht_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS)) u_up_index (
        .addr (up_addr),
        .idx  (up_idx)
    );

    assign up_cur = tbl_q.ent[up_idx];

    bht_hyst_next u_next (
        .cur   (up_cur),
        .taken (up_taken),
        .nxt   (up_nxt)
    );

    // lookup reads the registered table: old value during a same-index update
    assign lk_taken = tbl_q.ent[lk_idx][1];

    always_comb begin
        tbl_d = tbl_q;
        if (up_valid) begin
            tbl_d.ent[up_idx] = up_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    p_firm_nt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && up_cur == ST_NT_FIRM)
        |=> tbl_q.ent[$past(up_idx)] == ST_NT_FIRM);

    p_soft_nt_promote_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && up_cur == ST_NT_SOFT)
        |=> tbl_q.ent[$past(up_idx)] == ST_T_FIRM);

    p_firm_t_decay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && up_cur == ST_T_FIRM)
        |=> tbl_q.ent[$past(up_idx)] == ST_T_SOFT);

    p_soft_t_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && up_cur == ST_T_SOFT)
        |=> tbl_q.ent[$past(up_idx)] == ST_NT_FIRM);

    p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(tbl_q));

    p_lookup_reads_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && lk_idx == up_idx) |-> lk_taken == up_cur[1]);
endmodule

// File: tb/tb_hyst_branch_predictor.sv
module tb_hyst_branch_predictor;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lk_addr;
    logic        lk_taken;
    logic        up_valid;
    logic [31:0] up_addr;
    logic        up_taken;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    hyst_branch_predictor dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_addr  (lk_addr),
        .lk_taken (lk_taken),
        .up_valid (up_valid),
        .up_addr  (up_addr),
        .up_taken (up_taken)
    );

    typedef struct packed {
        logic        v;
        logic [31:0] ua;
        logic        t;
        logic [31:0] la;
        logic        exp;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VEC [0:NVEC-1] = '{
        '{1'b1, 32'h0000_0104, 1'b1, 32'h0000_0104, 1'b0},  // R2 00->01
        '{1'b1, 32'h0000_0104, 1'b0, 32'h0000_0104, 1'b0},  // R3 01->00
        '{1'b1, 32'h0000_0104, 1'b1, 32'h0000_0104, 1'b0},  // R2 00->01
        '{1'b1, 32'h0000_0104, 1'b1, 32'h0000_0104, 1'b1},  // R3 01->11
        '{1'b1, 32'h0000_0104, 1'b1, 32'h0000_0104, 1'b1},  // R4 11->11
        '{1'b1, 32'h0000_0104, 1'b0, 32'h0000_0104, 1'b1},  // R4 11->10
        '{1'b1, 32'h0000_0104, 1'b1, 32'h0000_0104, 1'b1},  // R5 10->11
        '{1'b1, 32'h0000_0104, 1'b0, 32'h0000_0104, 1'b1},  // R4 11->10
        '{1'b1, 32'h0000_0104, 1'b0, 32'h0000_0104, 1'b0},  // R5 10->00
        '{1'b1, 32'h0000_0104, 1'b0, 32'h0000_0104, 1'b0},  // R2 00->00
        '{1'b1, 32'h0000_0104, 1'b1, 32'h0000_0104, 1'b0},  // R2 00->01
        '{1'b1, 32'h0000_0104, 1'b1, 32'h0000_0104, 1'b1},  // R3 01->11
        '{1'b1, 32'h0000_0F07, 1'b0, 32'h0000_0104, 1'b1},  // R6 alias 11->10
        '{1'b1, 32'h0000_0005, 1'b0, 32'hABCD_0104, 1'b0},  // R6 alias 10->00
        '{1'b0, 32'h0000_0104, 1'b1, 32'h0000_0104, 1'b0},  // R8 idle
        '{1'b0, 32'h0000_0104, 1'b1, 32'h0000_0104, 1'b0},  // R8 idle
        '{1'b1, 32'h0000_0104, 1'b1, 32'h0000_0104, 1'b0},  // R8 proves 00 ->01
        '{1'b1, 32'h0000_0104, 1'b1, 32'h0000_0104, 1'b1},  // R3 01->11
        '{1'b1, 32'h0000_0104, 1'b1, 32'h0000_0108, 1'b0},  // R9 neighbour untouched
        '{1'b1, 32'h0000_0108, 1'b1, 32'h0000_0104, 1'b1}   // R9 entry kept
    };

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: lk_taken=%0b expected=%0b", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        up_valid = 1'b0;
        up_addr  = '0;
        up_taken = 1'b0;
    endtask

    task automatic upd(input logic [31:0] a, input logic t);
        @(negedge clk);
        up_valid = 1'b1;
        up_addr  = a;
        up_taken = t;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        lk_addr = '0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every entry clears to 00
        for (int i = 0; i < 64; i++) begin
            lk_addr = 32'(i) << 2;
            #1;
            check(lk_taken, 1'b0, "R1 reset entry");
        end

        // table of vectors: drive on a falling edge, sample after the next rising edge
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            up_valid = VEC[k].v;
            up_addr  = VEC[k].ua;
            up_taken = VEC[k].t;
            lk_addr  = VEC[k].la;
            @(negedge clk);
            idle_inputs();
            check(lk_taken, VEC[k].exp, $sformatf("vector %0d", k));
        end

        // R7: same-index update and lookup returns the old guess, new after edge
        upd(32'h0000_0018, 1'b1);          // idx 6 -> 01
        @(negedge clk);
        up_valid = 1'b1;
        up_addr  = 32'h0000_0018;
        up_taken = 1'b1;
        lk_addr  = 32'h0000_0018;
        #1;
        check(lk_taken, 1'b0, "R7 old value during update");
        @(negedge clk);
        idle_inputs();
        check(lk_taken, 1'b1, "R7 new value after edge");

        // R6 boundary: index 63 and index 0 are separate entries
        upd(32'h0000_00FC, 1'b1);
        upd(32'h0000_00FC, 1'b1);
        lk_addr = 32'h0000_00FC;
        #1;
        check(lk_taken, 1'b1, "R6 index 63 trained");
        lk_addr = 32'h0000_0000;
        #1;
        check(lk_taken, 1'b0, "R6 index 0 untouched");
        lk_addr = 32'hFFFF_FFFF;
        #1;
        check(lk_taken, 1'b1, "R6 high bits ignored");

        // R1: reset mid-run clears trained entries
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n   = 1'b1;
        lk_addr = 32'h0000_00FC;
        #1;
        check(lk_taken, 1'b0, "R1 reset clears trained entry");
        lk_addr = 32'h0000_0104;
        #1;
        check(lk_taken, 1'b0, "R1 reset clears second entry");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule